// File: doc/BRIEF.md
# Token-Ring Chained FIFO

This block builds one deep first-in first-out buffer out of a ring of identical storage stages. Every stage sees the same write data, write strobe and read strobe. A write token and a read token travel around the ring. Only the stage that holds the write token stores an incoming word. Only the stage that holds the read token puts its oldest word on the read port. When a stage uses its last location for a write or a read, it raises a one-cycle hand-off pulse on its expansion output. That pulse passes the matching token to the next stage. The last stage feeds the first, which closes the ring.

A per-stage select input, active low, marks the stage that holds both tokens after reset. Exactly one bit of this select must be low. Each stage reports its own active-low empty and full flags. The composite flags are the OR of these per-stage flags, so the composite flag asserts only when every stage asserts its own. The retransmit input is ignored and the half-full output is held inactive, because neither feature works in a chained arrangement. Total depth is `STAGES * DEPTH` words. The read port is first-word fall-through: whenever `empty_n` is high, `rd_data` shows the oldest word.

Top module: `dcf_chain`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `empty_n` is 0 and `full_n` is 1.
- R2: Words leave in the order they were accepted, including across stage boundaries and around the ring. While `empty_n` is 1, `rd_data` shows the oldest stored word.
- R3: `empty_n` is 0 exactly when no stage holds a word.
- R4: `full_n` is 0 exactly when all `STAGES*DEPTH` locations are occupied.
- R5: A write strobe while `full_n` is 0 stores nothing, even when a read is strobed in the same cycle.
- R6: A read strobe while `empty_n` is 0 removes nothing. A write strobed in the same cycle is still stored.
- R7: Operation is the same whichever single stage is selected by the low bit of `first_sel_n`.
- R8: `retx_n` has no effect on the stored data or the flags, and `half_full_n` stays 1.
- R9: A read and a write accepted in the same cycle both take effect, and the occupancy stays the same.
- R10: At every cycle after reset, exactly one stage holds the write token and exactly one stage holds the read token.
- R11: A stage that writes (or reads) its last location passes the write (or read) token to the next stage in the ring, effective at the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| first_sel_n | input | STAGES | Active-low select of the stage that holds both tokens after reset. Exactly one bit must be low. |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read strobe; removes the word shown on `rd_data` |
| rd_data | output | WIDTH | Oldest stored word, driven by the read-token stage |
| empty_n | output | 1 | Composite empty flag, active low |
| full_n | output | 1 | Composite full flag, active low |
| retx_n | input | 1 | Retransmit request; ignored in this configuration |
| half_full_n | output | 1 | Half-full flag; held inactive (1) |

## Verification
The bench runs the default three-stage, four-word configuration once for each possible first stage. For each, it fills the chain past one stage's capacity and on to full. A design that mishandles token hand-off repeats a word or reorders words at a stage boundary. A design that forms the flags with AND instead of OR reports full or empty after one stage fills or drains. The bench also strobes writes into a full chain and reads from an empty one. A design that fails to ignore these corrupts the order or the occupancy. It also mixes simultaneous reads and writes while `retx_n` toggles, which exposes broken count updates and any path that lets retransmit touch the pointers.

// File: rtl/dcf_pkg.sv
// Package dcf_pkg: types shared by the chained FIFO stages.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package dcf_pkg;
    // Hand-off pulses carried from one stage to the next in the ring.
    typedef struct packed {
        logic wr;   // write token passes on
        logic rd;   // read token passes on
    } xtok_t;
endpackage

// File: rtl/dcf_store.sv
// Module dcf_store: storage array of one stage, one write port and one
// asynchronous read port. Assumes the caller never writes and reads the
// same location in one cycle when that location holds live data.
module dcf_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Stores the incoming word on a write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Presents the word at the read address.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/dcf_stage.sv
// Module dcf_stage: one link of the token ring. It owns pointers and an
// occupancy count. It writes only while holding the write token and reads
// only while holding the read token. When it uses its last location it
// pulses the matching hand-off bit on xo. Assumes wr_go and rd_go are
// already qualified by the composite flags.
module dcf_stage
    import dcf_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_n,
    input  logic             wr_go,
    input  logic             rd_go,
    input  logic [WIDTH-1:0] wr_data,
    input  xtok_t            xi,
    output xtok_t            xo,
    output logic [WIDTH-1:0] rd_q,
    output logic             wtok,
    output logic             rtok,
    output logic             empty_n,
    output logic             full_n
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    // Qualifies the shared strobes by token ownership.
    always_comb begin
        do_wr = wr_go && wtok;
        do_rd = rd_go && rtok;
    end

    // Raises the hand-off pulses when the last location is used.
    always_comb begin
        xo.wr = do_wr && (wptr == LAST);
        xo.rd = do_rd && (rptr == LAST);
    end

    // Advances the write pointer and passes the write token along the ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            wtok <= !first_n;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            wtok <= (wtok && !xo.wr) || xi.wr;
        end
    end

    // Advances the read pointer and passes the read token along the ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
            rtok <= !first_n;
        end else begin
            if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            rtok <= (rtok && !xo.rd) || xi.rd;
        end
    end

    // Tracks how many words this stage holds.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
        endcase
    end

    // Forms this stage's active-low flags.
    always_comb begin
        empty_n = (count != '0);
        full_n  = (count != CAP);
    end

    dcf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_store (
        .clk   (clk),
        .we    (do_wr),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (rd_q)
    );

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_wr |-> (count != CAP));
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_rd |-> (count != '0));
    // R11
    wtok_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xi.wr |=> wtok);
    // R11
    rtok_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xi.rd |=> rtok);
endmodule

// File: rtl/dcf_chain.sv
// Module dcf_chain: ring of STAGES dcf_stage links forming one FIFO of
// STAGES*DEPTH words. The composite flags OR the per-stage active-low
// flags. Only the read-token stage is gated onto rd_data. Retransmit is
// ignored and half-full is held inactive. Assumes exactly one bit of
// first_sel_n is low while rst_n is low.
module dcf_chain
    import dcf_pkg::*;
#(
    parameter int WIDTH  = 9,
    parameter int DEPTH  = 4,
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] first_sel_n,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    output logic [WIDTH-1:0]  rd_data,
    output logic              empty_n,
    output logic              full_n,
    input  logic              retx_n,
    output logic              half_full_n
);
    xtok_t             xo_v [STAGES];
    logic [WIDTH-1:0]  q_v  [STAGES];
    logic [STAGES-1:0] wtok_v, rtok_v, empty_v, full_v;
    logic              wr_go, rd_go, retx_unused;

    // Qualifies the shared strobes by the composite flags.
    always_comb begin
        wr_go = wr_en && full_n;
        rd_go = rd_en && empty_n;
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        localparam int PREV = (i + STAGES - 1) % STAGES;
        dcf_stage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .first_n (first_sel_n[i]),
            .wr_go   (wr_go),
            .rd_go   (rd_go),
            .wr_data (wr_data),
            .xi      (xo_v[PREV]),
            .xo      (xo_v[i]),
            .rd_q    (q_v[i]),
            .wtok    (wtok_v[i]),
            .rtok    (rtok_v[i]),
            .empty_n (empty_v[i]),
            .full_n  (full_v[i])
        );
    end

    // Gates the read-token stage onto the shared read port.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < STAGES; i++)
            rd_data = rd_data | (q_v[i] & {WIDTH{rtok_v[i]}});
    end

    // Combines the per-stage active-low flags by OR.
    always_comb begin
        empty_n     = |empty_v;
        full_n      = |full_v;
        retx_unused = retx_n;
        half_full_n = 1'b1 | retx_unused;
    end

    // R10
    one_wtok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(wtok_v));
    // R10
    one_rtok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rtok_v));
    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_en) |=> !full_n);
    // R6
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_en) |=> !empty_n);
endmodule

// File: tb/test_dcf_chain.sv
module test_dcf_chain;
    localparam int W = 9, D = 4, N = 3, CAP = N * D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  first_sel_n = '1;
    logic          wr_en = 1'b0, rd_en = 1'b0, retx_n = 1'b1;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          empty_n, full_n, half_full_n;

    int tests = 0, fails = 0;
    int model [$];
    logic [W-1:0] seq = '0;

    always #4 clk = ~clk;

    dcf_chain #(.WIDTH(W), .DEPTH(D), .STAGES(N)) i_dcf_chain (
        .clk(clk), .rst_n(rst_n), .first_sel_n(first_sel_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
        .retx_n(retx_n), .half_full_n(half_full_n)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check head before edge, flags after.
    task automatic step(input logic w, input logic r, input logic rt);
        logic wok, rok;
        seq = seq + 9'd37;
        wr_en = w; rd_en = r; retx_n = rt; wr_data = seq;
        wok = w && (model.size() < CAP);
        rok = r && (model.size() > 0);
        if (model.size() > 0) check("R2 head", int'(rd_data), model[0]);
        @(negedge clk);
        if (rok) void'(model.pop_front());
        if (wok) model.push_back(int'(seq));
        check("R3 empty_n", int'(empty_n), int'(model.size() != 0));
        check("R4 full_n", int'(full_n), int'(model.size() != CAP));
        check("R8 half_full_n", int'(half_full_n), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < N; k++) begin
            // R7: each stage in turn holds the tokens at reset
            @(negedge clk);
            rst_n = 1'b0; first_sel_n = ~(N'(1) << k);
            wr_en = 0; rd_en = 0;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            model.delete();
            check("R1 empty_n", int'(empty_n), 0);
            check("R1 full_n", int'(full_n), 1);
            // R6: reads on empty remove nothing
            step(0, 1, 1); step(0, 1, 0);
            // R6: write with read on empty still stores
            step(1, 1, 1);
            // R2 R4: fill past one stage to full, then R5 overfill
            for (int i = 0; i < CAP + 2; i++) step(1, 0, logic'(i % 2));
            // R5: write plus read on full stores nothing
            step(1, 1, 0);
            // R9: mixed read and write traffic around the ring
            for (int i = 0; i < 3 * CAP; i++) step(1, 1, logic'(i % 3 == 0));
            // R2 R3: drain across stage boundaries
            for (int i = 0; i < CAP + 1; i++) step(0, 1, 1);
            // Partial fill and drain, bursty pattern
            for (int i = 0; i < 4 * CAP; i++)
                step(logic'((i % 5) != 4), logic'((i % 3) == 0), 1);
            while (model.size() > 0) step(0, 1, 1);
            step(0, 0, 1);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule